// File: doc/BRIEF.md
# Bus Interrupter with Acknowledge Daisy Chain

This block lets one slave card on a parallel backplane raise an interrupt and answer the matching acknowledge cycle. Local logic gives a single-cycle request pulse. The block holds that pulse as a pending request and pulls the active-low interrupt line low for as long as the request is pending.

The acknowledge daisy chain enters on `iackin_n` and leaves on `iackout_n`. While the card is requesting, a falling edge on the incoming chain is taken as the acknowledge meant for this card. The block then keeps the outgoing chain high and waits for data strobe 0. It places the configured status/ID byte on the low data byte and drives DTACK low until the address strobe returns high. Whenever the block is not holding an acknowledge, the outgoing chain copies the incoming chain, so cards further down are never blocked.

Every asynchronous bus input passes through a synchronizer with `SYNC_STAGES` flops (2 by default) before it is used.

Top module: `bus_interrupter`

## Requirements
- R1: During and after a synchronous active-low reset, `irq_n`, `iackout_n` and `dtack_n` are 1, `data_oe` is 0 and `data_out` is 0.
- R2: A one-cycle `irq_pulse` sampled at a clock edge makes `irq_n` low after that edge. `irq_n` stays low until an acknowledge completes.
- R3: When not holding an acknowledge, `iackout_n` follows `iackin_n` with a latency of `SYNC_STAGES` clock edges.
- R4: A request may be raised while `iackin_n` is already low. A chain that is low when the block starts requesting is passed on and never answered.
- R5: While requesting, a synchronized falling edge of `iackin_n` claims the cycle. From that point until release, `iackout_n` stays 1 with no low cycle.
- R6: After a claim, `dtack_n` stays 1 while `ds0_n` is high. It goes low `SYNC_STAGES`+1 edges after `ds0_n` falls.
- R7: While `dtack_n` is low, `data_oe` is 1 and `data_out` equals `status_id`. At all other times `data_oe` is 0 and `data_out` is 0.
- R8: `dtack_n` stays low until `as_n` returns high. It rises `SYNC_STAGES`+1 edges after that, and `irq_n` is released on the same edge unless another request was captured.
- R9: A request pulse that arrives after the claim, while waiting for the data strobe or while DTACK is driven, is kept. `irq_n` stays low after the acknowledge completes.
- R10: A request pulse on the same edge that completes an acknowledge is kept, and `irq_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_pulse | input | 1 | One-cycle interrupt request from local logic |
| status_id | input | 8 | Status/ID byte returned in the acknowledge cycle |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds0_n | input | 1 | Data strobe 0, active low, asynchronous |
| iackin_n | input | 1 | Incoming acknowledge daisy chain, active low, asynchronous |
| irq_n | output | 1 | Interrupt request line, active low |
| iackout_n | output | 1 | Outgoing acknowledge daisy chain, active low |
| dtack_n | output | 1 | Data transfer acknowledge, active low |
| data_out | output | 8 | Low data byte driven during the response |
| data_oe | output | 1 | Output enable for `data_out` |

## Verification
The bench raises a request while another card's acknowledge already holds the chain low. A design that reacts to a low level would answer a cycle meant for someone else. The bench also watches the outgoing chain on every cycle around a claim, where a design that releases the pass-through one cycle late leaks a low pulse downstream. It sweeps several status bytes against request pulses injected while waiting for the strobe, during DTACK, and on the very edge that completes the acknowledge. A design with a single sticky flag would lose the second interrupt in each of these cases. Strobe and address-strobe latencies are checked to the exact edge, so a missing or extra synchronizer stage shows up.

// File: rtl/bus_interrupter_pkg.sv
package bus_interrupter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CLAIM   = 2'd2,
        ST_RESPOND = 2'd3
    } intr_state_e;

    typedef struct packed {
        logic as_n;
        logic ds0_n;
        logic iack_n;
    } bus_lines_t;

    localparam int BUS_LINES = $bits(bus_lines_t);

    // True while the block owns an acknowledge cycle
    function automatic logic is_serving(input intr_state_e s);
        return (s == ST_CLAIM) || (s == ST_RESPOND);
    endfunction

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= '1;
                end else if (g == 0) begin
                    chain[g] <= d;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/intr_pending.sv
module intr_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic serving,
    input  logic ack_done,
    output logic pending
);
    logic queued;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            queued  <= 1'b0;
        end else if (ack_done) begin
            pending <= queued | pulse;
            queued  <= 1'b0;
        end else if (pulse) begin
            if (serving) begin
                queued <= 1'b1;
            end else begin
                pending <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/intr_fsm.sv
module intr_fsm
    import bus_interrupter_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pending,
    input  bus_lines_t  lines,
    output intr_state_e state,
    output logic        iack_fall,
    output logic        ack_done
);
    intr_state_e nxt;
    logic        iack_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            iack_prev <= 1'b1;
        end else begin
            state     <= nxt;
            iack_prev <= lines.iack_n;
        end
    end

    assign iack_fall = iack_prev & ~lines.iack_n;
    assign ack_done  = (state == ST_RESPOND) && lines.as_n;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (pending) nxt = ST_ARMED;
            ST_ARMED:   if (iack_fall) nxt = ST_CLAIM;
            ST_CLAIM:   if (!lines.ds0_n) nxt = ST_RESPOND;
            ST_RESPOND: if (lines.as_n) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bus_interrupter.sv
module bus_interrupter
    import bus_interrupter_pkg::*;
#(
    parameter int ID_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_pulse,
    input  logic [ID_W-1:0] status_id,
    input  logic            as_n,
    input  logic            ds0_n,
    input  logic            iackin_n,
    output logic            irq_n,
    output logic            iackout_n,
    output logic            dtack_n,
    output logic [ID_W-1:0] data_out,
    output logic            data_oe
);
    bus_lines_t  raw_lines, sync_lines;
    intr_state_e state;
    logic        iack_fall, ack_done, pending, responding;

    assign raw_lines = '{as_n: as_n, ds0_n: ds0_n, iack_n: iackin_n};

    bus_line_sync #(.W(BUS_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lines),
        .q     (sync_lines)
    );

    intr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .lines     (sync_lines),
        .state     (state),
        .iack_fall (iack_fall),
        .ack_done  (ack_done)
    );

    intr_pending u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse    (irq_pulse),
        .serving  (is_serving(state)),
        .ack_done (ack_done),
        .pending  (pending)
    );

    assign responding = (state == ST_RESPOND);
    assign irq_n      = ~pending;
    assign dtack_n    = ~responding;
    assign data_oe    = responding;
    assign data_out   = responding ? status_id : '0;
    // Hold the chain high on the claiming edge so no low pulse leaks
    assign iackout_n  = is_serving(state) | sync_lines.iack_n
                      | ((state == ST_ARMED) & iack_fall);
endmodule

// File: rtl/bus_interrupter_checker.sv
module bus_interrupter_checker #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_pulse,
    input logic [ID_W-1:0] status_id,
    input logic            as_n,
    input logic            ds0_n,
    input logic            irq_n,
    input logic            iackout_n,
    input logic            dtack_n,
    input logic [ID_W-1:0] data_out,
    input logic            data_oe
);
    a_r1_reset_inactive: assert property (@(posedge clk)
        !rst_n |=> (irq_n && iackout_n && dtack_n && !data_oe));

    a_r2_pulse_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_n);

    a_r5_chain_held_in_response: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> iackout_n);

    a_r6_dtack_after_ds0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> !$past(ds0_n));

    a_r7_id_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (data_out == status_id));

    a_r8_release_after_as: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_n) |-> $past(as_n));

    a_r9_irq_held_in_response: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> !irq_n);
endmodule

bind bus_interrupter bus_interrupter_checker #(.ID_W(ID_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pulse (irq_pulse),
    .status_id (status_id),
    .as_n      (as_n),
    .ds0_n     (ds0_n),
    .irq_n     (irq_n),
    .iackout_n (iackout_n),
    .dtack_n   (dtack_n),
    .data_out  (data_out),
    .data_oe   (data_oe)
);

// File: tb/bus_interrupter_test.sv
module bus_interrupter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pulse = 1'b0;
    logic [7:0] status_id = 8'h00;
    logic       as_n = 1'b1;
    logic       ds0_n = 1'b1;
    logic       iackin_n = 1'b1;
    logic       irq_n, iackout_n, dtack_n, data_oe;
    logic [7:0] data_out;
    int         checks = 0;
    int         fails = 0;

    always #5 clk = ~clk;

    bus_interrupter #(.ID_W(8), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .status_id(status_id),
        .as_n(as_n), .ds0_n(ds0_n), .iackin_n(iackin_n), .irq_n(irq_n),
        .iackout_n(iackout_n), .dtack_n(dtack_n), .data_out(data_out),
        .data_oe(data_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic nwait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_once();
        irq_pulse = 1'b1;
        @(negedge clk);
        irq_pulse = 1'b0;
    endtask

    // phase: 0 none, 1 while waiting for strobe, 2 during DTACK, 3 on ack edge
    task automatic serve(input logic [7:0] id, input int phase);
        status_id = id;
        if (irq_n) begin
            pulse_once();
            chk("R2 irq low after pulse", irq_n, 0);
        end
        nwait(2);
        as_n = 1'b0;
        iackin_n = 1'b0;
        nwait(1);
        chk("R5 chain high on claim", iackout_n, 1);
        nwait(1);
        chk("R5 no leak on claim edge", iackout_n, 1);
        nwait(1);
        chk("R5 chain held while claimed", iackout_n, 1);
        if (phase == 1) pulse_once(); else nwait(1);
        nwait(2);
        chk("R6 no dtack before ds0", dtack_n, 1);
        chk("R7 bus released before dtack", data_oe, 0);
        ds0_n = 1'b0;
        nwait(2);
        chk("R6 dtack latency", dtack_n, 1);
        nwait(1);
        chk("R6 dtack after ds0", dtack_n, 0);
        chk("R7 oe in response", data_oe, 1);
        chk("R7 status byte", data_out, id);
        chk("R5 chain held in response", iackout_n, 1);
        chk("R2 irq held in response", irq_n, 0);
        if (phase == 2) pulse_once(); else nwait(1);
        nwait(2);
        chk("R8 dtack held while as low", dtack_n, 0);
        as_n = 1'b1;
        iackin_n = 1'b1;
        ds0_n = 1'b1;
        nwait(2);
        chk("R8 dtack held until as synced", dtack_n, 0);
        if (phase == 3) irq_pulse = 1'b1;
        nwait(1);
        irq_pulse = 1'b0;
        chk("R8 dtack released", dtack_n, 1);
        chk("R7 bus released after", data_oe, 0);
        chk("R7 data zero after", data_out, 0);
        if (phase == 1) chk("R9 pulse in claim kept", irq_n, 0);
        else if (phase == 2) chk("R9 pulse in dtack kept", irq_n, 0);
        else if (phase == 3) chk("R10 pulse on ack edge kept", irq_n, 0);
        else chk("R8 irq released with dtack", irq_n, 1);
        nwait(2);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        nwait(3);
        chk("R1 irq_n reset", irq_n, 1);
        chk("R1 iackout_n reset", iackout_n, 1);
        chk("R1 dtack_n reset", dtack_n, 1);
        chk("R1 data_oe reset", data_oe, 0);
        chk("R1 data_out reset", data_out, 0);
        rst_n = 1'b1;
        nwait(2);

        // R3 pass-through latency while idle
        iackin_n = 1'b0;
        nwait(1);
        chk("R3 latency low", iackout_n, 1);
        nwait(1);
        chk("R3 pass low", iackout_n, 0);
        // R4 request while chain already low
        pulse_once();
        nwait(3);
        chk("R4 irq raised with chain low", irq_n, 0);
        chk("R4 low chain passed on", iackout_n, 0);
        as_n = 1'b0;
        ds0_n = 1'b0;
        nwait(5);
        chk("R4 low level not claimed", dtack_n, 1);
        chk("R4 chain still passed", iackout_n, 0);
        as_n = 1'b1;
        ds0_n = 1'b1;
        iackin_n = 1'b1;
        nwait(1);
        chk("R3 latency high", iackout_n, 0);
        nwait(1);
        chk("R3 pass high", iackout_n, 1);
        nwait(2);

        // Sweep status bytes against pulse injection phases
        for (int k = 0; k < 6; k++) begin
            for (int ph = 0; ph < 4; ph++) begin
                serve(8'((k * 8'h2b) ^ (ph << 6) ^ 8'h81), ph);
            end
        end
        // R9 drain: a queued request is served once more, then released
        serve(8'hff, 0);
        chk("R9 all requests drained", irq_n, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule